// File: doc/BRIEF.md
# Gated Event Counter with PWM Gate Generator

This block counts rising edges on an asynchronous event input into a 16-bit counter. The counter only advances while a gate signal is open. The gate comes from one of two sources, chosen by a mode bit. One is an external enable pin. The other is an internal PWM generator that runs from a prescaled copy of the system clock. Each PWM period begins with a closed (low) interval and continues with an open (high) interval. The period length and the closed length are each programmed as a 16-bit value through a byte-wide register write port.

Software loads a period value and an off-time value, each one as a high byte followed by a low byte. The low-byte write commits the whole 16-bit value. The generator then adopts the committed values at its next period boundary, so a period is never cut short or mixed. An off-time of all ones holds the PWM output low permanently. If the off-time is not below the period value, the generator is never allowed to open the gate. Because the gate cuts counting independently of event timing, a count at a gate edge may be lost or gained. Interrupts and overflow handling are not part of the block: the counter simply wraps.

Top module: `gated_evcnt`

## Requirements
- R1: With period value P and off-time value D (D < P), the PWM output stays high for (P - D) prescaled ticks in each period.
- R2: Each PWM period starts with a low interval of (D + 1) prescaled ticks, so a full period lasts (P + 1) ticks.
- R3: When D equals 0xFFFF, the PWM output stays low at all times.
- R4: The prescaler select input picks the tick spacing in system clock cycles: value s in 0..5 gives 2^(s+1), and the values 6 and 7 give 64.
- R5: Register addresses on wr_addr_i: 0 = period high byte, 1 = period low byte, 2 = off-time high byte, 3 = off-time low byte, 4 = control (bit 0 = gate mode). A high-byte write alone changes nothing. A low-byte write commits {last high byte, low byte}.
- R6: A committed value takes effect only at the next period boundary. The interval in progress finishes with the old values.
- R7: With gate mode 0, the synchronized gate pin opens the gate, and the PWM output has no effect on counting.
- R8: With gate mode 1, the PWM output opens the gate and the pin has no effect. While D >= P the gate stays closed.
- R9: The count increments by exactly one for each rising event edge seen while the gate is open. Falling edges are never counted.
- R10: Reset clears the count to 0, drives the PWM output low and clears the gate mode to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 1 | Asynchronous event input; rising edges are counted |
| gate_pin_i | input | 1 | External gate enable, used in gate mode 0 |
| psc_sel_i | input | 3 | Prescaler select for the PWM tick |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 8 | Register write data |
| pwm_o | output | 1 | PWM gate waveform |
| count_o | output | 16 | Event count |

## Verification
The PWM period counter, the active register copies and the prescaler all show up directly in pwm_o. A corrupted period count, a wrong boundary load or a wrong divider changes the measured high or low run length within the period where the fault occurs. The bench therefore measures whole high and low runs in system cycles. A wrong gate selection or a wrong synchronizer edge shows up in count_o a few cycles after the next event burst, and bursts are sent both inside the open and inside the closed windows of each gate source.

// File: rtl/gec_pkg.sv
package gec_pkg;

    typedef enum logic [2:0] {
        ADR_PER_HI = 3'd0,
        ADR_PER_LO = 3'd1,
        ADR_OFF_HI = 3'd2,
        ADR_OFF_LO = 3'd3,
        ADR_CTRL   = 3'd4
    } gec_addr_e;

    localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/gec_prescaler.sv
module gec_prescaler #(
    parameter int PSC_STAGES = 6,
    parameter int SEL_W      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);

    typedef struct packed {
        logic [PSC_STAGES-1:0] div;
    } psc_state_t;

    psc_state_t            st_d, st_q;
    logic [SEL_W-1:0]      eff_sel;
    logic [PSC_STAGES-1:0] mask;

    always_comb begin
        st_d = st_q;
        st_d.div = st_q.div + 1'b1;

        if (sel_i > SEL_W'(PSC_STAGES - 1)) begin
            eff_sel = SEL_W'(PSC_STAGES - 1);
        end else begin
            eff_sel = sel_i;
        end

        for (int i = 0; i < PSC_STAGES; i++) begin
            mask[i] = ({{(32-SEL_W){1'b0}}, eff_sel} >= 32'(i));
        end

        tick_o = ((st_q.div & mask) == mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/gec_regfile.sv
module gec_regfile
    import gec_pkg::*;
#(
    parameter int VAL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [2:0]       wr_addr_i,
    input  logic [7:0]       wr_data_i,
    output logic [VAL_W-1:0] per_o,
    output logic [VAL_W-1:0] off_o,
    output logic             mode_o
);

    localparam int HI_W = VAL_W - BYTE_W;

    typedef struct packed {
        logic [HI_W-1:0]  per_hi;
        logic [HI_W-1:0]  off_hi;
        logic [VAL_W-1:0] per;
        logic [VAL_W-1:0] off;
        logic             mode;
    } reg_state_t;

    reg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            case (gec_addr_e'(wr_addr_i))
                ADR_PER_HI: st_d.per_hi = wr_data_i[HI_W-1:0];
                ADR_PER_LO: st_d.per    = {st_q.per_hi, wr_data_i};
                ADR_OFF_HI: st_d.off_hi = wr_data_i[HI_W-1:0];
                ADR_OFF_LO: st_d.off    = {st_q.off_hi, wr_data_i};
                ADR_CTRL:   st_d.mode   = wr_data_i[0];
                default:    st_d = st_q;
            endcase
        end
        per_o  = st_q.per;
        off_o  = st_q.off;
        mode_o = st_q.mode;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/gec_pwm.sv
module gec_pwm #(
    parameter int VAL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [VAL_W-1:0] per_new_i,
    input  logic [VAL_W-1:0] off_new_i,
    output logic             pwm_o,
    output logic             valid_o,
    output logic [VAL_W-1:0] act_per_o,
    output logic [VAL_W-1:0] act_off_o
);

    localparam logic [VAL_W-1:0] OFF_STUCK = {VAL_W{1'b1}};

    typedef struct packed {
        logic [VAL_W-1:0] pcnt;
        logic [VAL_W-1:0] per;
        logic [VAL_W-1:0] off;
        logic             pwm;
    } pwm_state_t;

    pwm_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick_i) begin
            if (st_q.pcnt == st_q.per) begin
                st_d.pcnt = '0;
                st_d.per  = per_new_i;
                st_d.off  = off_new_i;
            end else begin
                st_d.pcnt = st_q.pcnt + 1'b1;
            end
            st_d.pwm = (st_d.off != OFF_STUCK) && (st_d.pcnt > st_d.off);
        end
        pwm_o     = st_q.pwm;
        valid_o   = (st_q.off < st_q.per);
        act_per_o = st_q.per;
        act_off_o = st_q.off;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/gec_evcount.sv
module gec_evcount #(
    parameter int CNT_W  = 16,
    parameter int SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_i,
    input  logic             gate_pin_i,
    input  logic             mode_i,
    input  logic             pwm_i,
    input  logic             pwm_valid_i,
    output logic [CNT_W-1:0] count_o,
    output logic             gate_o
);

    typedef struct packed {
        logic [SYNC_N:0]   evt_s;
        logic [SYNC_N-1:0] pin_s;
        logic [CNT_W-1:0]  cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       rise;

    always_comb begin
        st_d       = st_q;
        st_d.evt_s = {st_q.evt_s[SYNC_N-1:0], evt_i};
        st_d.pin_s = {st_q.pin_s[SYNC_N-2:0], gate_pin_i};

        rise   = st_q.evt_s[SYNC_N-1] & ~st_q.evt_s[SYNC_N];
        gate_o = mode_i ? (pwm_i & pwm_valid_i) : st_q.pin_s[SYNC_N-1];

        if (rise && gate_o) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        count_o = st_q.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/gated_evcnt.sv
module gated_evcnt #(
    parameter int  CNT_W      = 16,
    parameter int  VAL_W      = 16,
    parameter int  PSC_STAGES = 6,
    localparam int SEL_W      = $clog2(PSC_STAGES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_i,
    input  logic             gate_pin_i,
    input  logic [SEL_W-1:0] psc_sel_i,
    input  logic             wr_en_i,
    input  logic [2:0]       wr_addr_i,
    input  logic [7:0]       wr_data_i,
    output logic             pwm_o,
    output logic [CNT_W-1:0] count_o
);

    logic             psc_tick;
    logic [VAL_W-1:0] shd_per;
    logic [VAL_W-1:0] shd_off;
    logic             gate_mode;
    logic             pwm_valid;
    logic [VAL_W-1:0] act_per;
    logic [VAL_W-1:0] act_off;
    logic             cnt_gate;

    gec_prescaler #(
        .PSC_STAGES(PSC_STAGES),
        .SEL_W     (SEL_W)
    ) u_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .sel_i (psc_sel_i),
        .tick_o(psc_tick)
    );

    gec_regfile #(
        .VAL_W(VAL_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (wr_en_i),
        .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i),
        .per_o    (shd_per),
        .off_o    (shd_off),
        .mode_o   (gate_mode)
    );

    gec_pwm #(
        .VAL_W(VAL_W)
    ) u_pwm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (psc_tick),
        .per_new_i(shd_per),
        .off_new_i(shd_off),
        .pwm_o    (pwm_o),
        .valid_o  (pwm_valid),
        .act_per_o(act_per),
        .act_off_o(act_off)
    );

    gec_evcount #(
        .CNT_W (CNT_W),
        .SYNC_N(2)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt_i),
        .gate_pin_i (gate_pin_i),
        .mode_i     (gate_mode),
        .pwm_i      (pwm_o),
        .pwm_valid_i(pwm_valid),
        .count_o    (count_o),
        .gate_o     (cnt_gate)
    );

endmodule

// File: rtl/gec_checker.sv
module gec_checker #(
    parameter int CNT_W = 16,
    parameter int VAL_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pwm_o,
    input logic [CNT_W-1:0] count_o,
    input logic             tick,
    input logic             gate,
    input logic [VAL_W-1:0] act_per,
    input logic [VAL_W-1:0] act_off
);

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o != $past(count_o)) |-> (count_o == CNT_W'($past(count_o) + 1'b1))); // R9

    AST_CLOSED_GATE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !gate |=> $stable(count_o)); // R9

    AST_PWM_HIGH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_o |-> ((act_off < act_per) && (act_off != {VAL_W{1'b1}}))); // R3

    AST_PWM_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_o != $past(pwm_o)) |-> $past(tick)); // R4

endmodule

bind gated_evcnt gec_checker #(
    .CNT_W(CNT_W),
    .VAL_W(VAL_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .pwm_o  (pwm_o),
    .count_o(count_o),
    .tick   (psc_tick),
    .gate   (cnt_gate),
    .act_per(act_per),
    .act_off(act_off)
);

// File: tb/sim_gated_evcnt.sv
`timescale 1ns/1ps
module sim_gated_evcnt;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt = 1'b0;
    logic        pin = 1'b0;
    logic [2:0]  sel = 3'd0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [7:0]  wdata = 8'd0;
    logic        pwm;
    logic [15:0] cnt;

    int          checks = 0;
    int          errors = 0;
    longint      cyc = 0;
    logic [15:0] exp_cnt = 16'd0;
    bit          done = 1'b0;

    gated_evcnt u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt),
        .gate_pin_i(pin),
        .psc_sel_i (sel),
        .wr_en_i   (wr_en),
        .wr_addr_i (addr),
        .wr_data_i (wdata),
        .pwm_o     (pwm),
        .count_o   (cnt)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        summary();
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint div_of(input logic [2:0] s);
        return (s > 3'd5) ? 64 : (longint'(2) << s);
    endfunction

    function automatic longint exp_high(input int p, input int d, input logic [2:0] s);
        return longint'(p - d) * div_of(s);
    endfunction

    function automatic longint exp_low(input int d, input logic [2:0] s);
        return longint'(d + 1) * div_of(s);
    endfunction

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic program_vals(input logic [15:0] p, input logic [15:0] d);
        wr(3'd0, p[15:8]);
        wr(3'd1, p[7:0]);
        wr(3'd2, d[15:8]);
        wr(3'd3, d[7:0]);
    endtask

    task automatic wait_pwm(input logic v, output longint t);
        int n = 0;
        @(negedge clk);
        while (pwm !== v && n < 30000) begin
            @(negedge clk);
            n++;
        end
        if (n >= 30000) chk(1'b0, "wait for pwm level", longint'(pwm), longint'(v));
        t = cyc;
    endtask

    task automatic wait_rise(output longint t);
        longint tx;
        wait_pwm(1'b0, tx);
        wait_pwm(1'b1, t);
    endtask

    task automatic measure(output longint hi, output longint lo);
        longint t0, t1, t2;
        wait_rise(t0);
        wait_rise(t0);
        wait_pwm(1'b0, t1);
        wait_pwm(1'b1, t2);
        hi = t1 - t0;
        lo = t2 - t1;
    endtask

    task automatic events(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            evt = 1'b1;
            repeat (2) @(negedge clk);
            evt = 1'b0;
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic ev_check(input int n, input bit counted, input string req);
        events(n);
        repeat (6) @(negedge clk);
        if (counted) exp_cnt = exp_cnt + 16'(n);
        chk(cnt == exp_cnt, req, longint'(cnt), longint'(exp_cnt));
    endtask

    initial begin
        longint hi, lo, t0, t1;
        int     p, d, highs;
        void'($urandom(32'h5EED));

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cnt == 16'd0, "R10 count after reset", longint'(cnt), 0);
        chk(pwm == 1'b0, "R10 pwm after reset", longint'(pwm), 0);
        pin = 1'b1;
        repeat (4) @(negedge clk);
        ev_check(3, 1'b1, "R10 mode cleared, pin gate in use");

        pin = 1'b0;
        repeat (4) @(negedge clk);
        ev_check(5, 1'b0, "R7 pin low blocks");
        pin = 1'b1;
        repeat (4) @(negedge clk);
        ev_check(5, 1'b1, "R9 pin high counts rising edges");

        for (int k = 0; k < 6; k++) begin
            pin = 1'($urandom % 2);
            repeat (4) @(negedge clk);
            ev_check(1 + int'($urandom % 8), pin, "R7 random pin burst");
        end

        sel = 3'd0;
        program_vals(16'd9, 16'd3);
        measure(hi, lo);
        chk(hi == exp_high(9, 3, 3'd0), "R1 high interval", hi, exp_high(9, 3, 3'd0));
        chk(lo == exp_low(3, 3'd0), "R2 low interval", lo, exp_low(3, 3'd0));

        for (int k = 0; k < 6; k++) begin
            p   = 2 + int'($urandom % 19);
            d   = int'($urandom % p);
            sel = 3'($urandom % 8);
            program_vals(16'(p), 16'(d));
            measure(hi, lo);
            chk(hi == exp_high(p, d, sel), "R1 R4 random high", hi, exp_high(p, d, sel));
            chk(lo == exp_low(d, sel), "R2 R4 random low", lo, exp_low(d, sel));
        end

        sel = 3'd0;
        program_vals(16'd9, 16'd3);
        wr(3'd0, 8'h01);
        measure(hi, lo);
        chk(hi == exp_high(9, 3, 3'd0), "R5 high byte alone ignored", hi, exp_high(9, 3, 3'd0));
        wr(3'd1, 8'h09);
        measure(hi, lo);
        chk(hi == exp_high(265, 3, 3'd0), "R5 low byte commits", hi, exp_high(265, 3, 3'd0));

        program_vals(16'd1000, 16'd900);
        wait_rise(t0);
        wait_rise(t0);
        wait_pwm(1'b0, t0);
        program_vals(16'd9, 16'd3);
        wait_pwm(1'b1, t1);
        chk((t1 - t0) == exp_low(900, 3'd0), "R6 interval in progress keeps old value",
            t1 - t0, exp_low(900, 3'd0));
        measure(hi, lo);
        chk(hi == exp_high(9, 3, 3'd0), "R6 new value after boundary", hi, exp_high(9, 3, 3'd0));

        program_vals(16'd10, 16'hFFFF);
        repeat (200) @(negedge clk);
        highs = 0;
        for (int i = 0; i < 500; i++) begin
            @(negedge clk);
            if (pwm) highs++;
        end
        chk(highs == 0, "R3 forced low", highs, 0);

        wr(3'd4, 8'h01);
        program_vals(16'd1000, 16'd0);
        wait_rise(t0);
        wait_rise(t0);
        pin = 1'b0;
        repeat (10) @(negedge clk);
        ev_check(20, 1'b1, "R8 pwm high opens gate, pin ignored");

        program_vals(16'd1000, 16'd900);
        wait_rise(t0);
        wait_rise(t0);
        wait_pwm(1'b0, t0);
        pin = 1'b1;
        repeat (10) @(negedge clk);
        ev_check(20, 1'b0, "R8 pwm low closes gate, pin ignored");

        program_vals(16'd5, 16'd5);
        repeat (100) @(negedge clk);
        ev_check(10, 1'b0, "R8 off not below period keeps gate closed");

        wr(3'd4, 8'h00);
        pin = 1'b1;
        repeat (4) @(negedge clk);
        ev_check(4, 1'b1, "R7 mode 0 returns to pin gate");

        summary();
    end

endmodule